// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block is the local interrupt front end that sits beside one processor core in a multi-core system. It combines 32 private interrupt IDs (0 to 31) with a set of shared interrupt lines that a distributor has already routed to this core and turned into level-high signals (IDs 32 and up). For each ID it holds an enable flag, a latched pending flag for edge and software events, and an active flag. The pick among these is fixed: the lowest-numbered ID that is pending, enabled and not active wins.

Software works through a small register window with ID-number commands. Writing an ID to one command register enables it, writing to another disables it, and writing to a third ends its service. Reading the ready register returns the winning ID and marks it active, so it is not offered again until it completes. When nothing is ready, the read returns all ones. A packed write of an ID and a target-core mask sends an inter-processor interrupt. The block drives it onto a broadcast output, and takes the broadcast of every core (its own included) on an input, setting the pending flag when its own bit in the mask is set.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the irq output is low, the interface is off (control register at 0x000 reads 0), every ID is disabled and a read of the ready register at 0x06C returns 32'hFFFFFFFF.
- R2: Bit 0 of the control register at 0x000 turns the interface on and reads back. While it is 0 the irq output stays low and a ready read returns 32'hFFFFFFFF without changing any ID's state.
- R3: Writing an ID to 0x0A0 enables it and writing an ID to 0x0A4 disables it. A disabled ID never raises irq and is never returned by a ready read. Values of NUM_IDS or more are ignored.
- R4: A read of 0x06C returns, in the cycle after the read strobe, the lowest-numbered ID that is pending, enabled and not active, and makes that ID active. An active ID is not returned again, and with no candidate the read returns 32'hFFFFFFFF.
- R5: Writing an ID to 0x0B4 clears its active flag. A level-sensed ID whose line is still asserted is then offered again.
- R6: Sense for private ID n is the 2-bit field at bits [2*(n%16)+1 : 2*(n%16)] of the word at 0x014 (IDs 0 to 15) or 0x018 (IDs 16 to 31): 0 level high, 1 level low, 2 rising edge, 3 falling edge. An edge is latched as pending until the ID is read from the ready register.
- R7: A level-sensed private ID is pending exactly while its line is at the asserted level. Removing the level before the ID is read withdraws it.
- R8: A write to 0x060 with ID in bits [3:0] and target mask in bits [15:8] produces a one-cycle ipiSendValid pulse in the next cycle carrying that ID and mask. A received broadcast sets the pending flag of that ID only when mask bit CPU_ID is set.
- R9: Shared line j is ID 32+j, sensed as level high. The irq output is high exactly while the interface is on and some ID is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 12 | Byte offset within the local window |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| privIrq | input | 32 | Private interrupt lines, IDs 0 to 31 |
| sharedIrq | input | NUM_SHARED | Routed shared lines, level high, IDs 32 and up |
| ipiRecvValid | input | 1 | Incoming inter-processor broadcast valid |
| ipiRecvId | input | 4 | Incoming broadcast ID |
| ipiRecvMask | input | NUM_CPUS | Incoming broadcast target mask |
| ipiSendValid | output | 1 | Outgoing inter-processor broadcast valid |
| ipiSendId | output | 4 | Outgoing broadcast ID |
| ipiSendMask | output | NUM_CPUS | Outgoing broadcast target mask |
| irq | output | 1 | Interrupt request to the core |

## Verification
Every cycle, the assertions check that irq is never high while the interface is off, that an acknowledged ID is active in the next cycle, that a completion or a disable takes effect in the next cycle, that an acknowledge happens only with a valid candidate, and that a send write always produces the broadcast pulse. Only the bench's scenarios can show which ID wins when several are pending, that the reserved idle value comes back when nothing is ready, that edge events are latched while level events follow the line, and that an inter-processor write sent to other cores only leaves this core's state untouched.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;

  localparam int CMD_ID_W = 8;
  localparam int PRIV_IDS = 32;

  localparam logic [11:0] OFF_CTRL   = 12'h000;
  localparam logic [11:0] OFF_SENSE0 = 12'h014;
  localparam logic [11:0] OFF_SENSE1 = 12'h018;
  localparam logic [11:0] OFF_IPI    = 12'h060;
  localparam logic [11:0] OFF_READY  = 12'h06C;
  localparam logic [11:0] OFF_ENA    = 12'h0A0;
  localparam logic [11:0] OFF_DIS    = 12'h0A4;
  localparam logic [11:0] OFF_EOI    = 12'h0B4;

  localparam logic [31:0] IDLE_ID = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_LVL_LO = 2'd1,
    SENSE_RISE   = 2'd2,
    SENSE_FALL   = 2'd3
  } sense_e;

  typedef struct packed {
    logic                setEn;
    logic                clrEn;
    logic                eoi;
    logic                ack;
    logic [CMD_ID_W-1:0] cmdId;
  } ctl_strb_t;

endpackage

// File: rtl/cpu_irq_ctrl.sv
module cpu_irq_ctrl
  import cpu_irq_pkg::*;
#(
  parameter int NUM_IDS  = 64,
  parameter int NUM_CPUS = 4,
  parameter int ID_W     = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [11:0]         busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic                readyValid,
  input  logic [ID_W-1:0]     readyId,
  output logic                ifaceOn,
  output logic [63:0]         senseCfg,
  output ctl_strb_t           strb,
  output logic                ipiSendValid,
  output logic [3:0]          ipiSendId,
  output logic [NUM_CPUS-1:0] ipiSendMask
);

  logic cmdInRange;
  logic wrIpi;

  assign cmdInRange = (busWrData < 32'(NUM_IDS));
  assign wrIpi      = busWrEn && (busAddr == OFF_IPI);

  always_comb begin
    strb.setEn = busWrEn && (busAddr == OFF_ENA) && cmdInRange;
    strb.clrEn = busWrEn && (busAddr == OFF_DIS) && cmdInRange;
    strb.eoi   = busWrEn && (busAddr == OFF_EOI) && cmdInRange;
    strb.ack   = busRdEn && (busAddr == OFF_READY) && readyValid;
    strb.cmdId = busWrData[CMD_ID_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifaceOn      <= 1'b0;
      senseCfg     <= '0;
      ipiSendValid <= 1'b0;
      ipiSendId    <= '0;
      ipiSendMask  <= '0;
    end else begin
      if (busWrEn && busAddr == OFF_CTRL)   ifaceOn        <= busWrData[0];
      if (busWrEn && busAddr == OFF_SENSE0) senseCfg[31:0]  <= busWrData;
      if (busWrEn && busAddr == OFF_SENSE1) senseCfg[63:32] <= busWrData;
      ipiSendValid <= wrIpi;
      if (wrIpi) begin
        ipiSendId   <= busWrData[3:0];
        ipiSendMask <= busWrData[8 +: NUM_CPUS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (busRdEn) begin
      case (busAddr)
        OFF_CTRL:   busRdData <= {31'b0, ifaceOn};
        OFF_SENSE0: busRdData <= senseCfg[31:0];
        OFF_SENSE1: busRdData <= senseCfg[63:32];
        OFF_READY:  busRdData <= readyValid ? 32'(readyId) : IDLE_ID;
        default:    busRdData <= '0;
      endcase
    end
  end

  // R8: every send write yields a broadcast pulse in the next cycle
  a_r8_ipi_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrIpi |=> ipiSendValid);

  // R4: an acknowledge only happens with the interface on and a winner present
  a_r4_ack_needs_winner: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |-> (ifaceOn && readyValid));

endmodule

// File: rtl/cpu_irq_datapath.sv
module cpu_irq_datapath
  import cpu_irq_pkg::*;
#(
  parameter int NUM_SHARED = 32,
  parameter int NUM_CPUS   = 4,
  parameter int CPU_ID     = 0,
  parameter int NUM_IDS    = PRIV_IDS + NUM_SHARED,
  parameter int ID_W       = $clog2(NUM_IDS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_strb_t             strb,
  input  logic                  ifaceOn,
  input  logic [63:0]           senseCfg,
  input  logic [PRIV_IDS-1:0]   privIrq,
  input  logic [NUM_SHARED-1:0] sharedIrq,
  input  logic                  ipiRecvValid,
  input  logic [3:0]            ipiRecvId,
  input  logic [NUM_CPUS-1:0]   ipiRecvMask,
  output logic                  readyValid,
  output logic [ID_W-1:0]       readyId
);

  logic [NUM_IDS-1:0]  enableQ, activeQ, pendQ;
  logic [NUM_IDS-1:0]  lvlHit, edgeHit, ipiHit, cand;
  logic [PRIV_IDS-1:0] prevQ;
  logic [ID_W-1:0]     cmdIdx;
  logic                found;

  assign cmdIdx = strb.cmdId[ID_W-1:0];

  for (genvar i = 0; i < PRIV_IDS; i++) begin : g_priv
    sense_e mode;
    assign mode = sense_e'(senseCfg[2*i +: 2]);
    always_comb begin
      lvlHit[i]  = 1'b0;
      edgeHit[i] = 1'b0;
      case (mode)
        SENSE_LVL_HI: lvlHit[i]  = privIrq[i];
        SENSE_LVL_LO: lvlHit[i]  = !privIrq[i];
        SENSE_RISE:   edgeHit[i] = privIrq[i] && !prevQ[i];
        SENSE_FALL:   edgeHit[i] = !privIrq[i] && prevQ[i];
        default:      lvlHit[i]  = 1'b0;
      endcase
    end
  end

  for (genvar j = 0; j < NUM_SHARED; j++) begin : g_shared
    assign lvlHit[PRIV_IDS+j]  = sharedIrq[j];
    assign edgeHit[PRIV_IDS+j] = 1'b0;
  end

  always_comb begin
    ipiHit = '0;
    if (ipiRecvValid && ipiRecvMask[CPU_ID]) ipiHit[ipiRecvId] = 1'b1;
  end

  assign cand = (lvlHit | pendQ) & enableQ & ~activeQ;

  always_comb begin
    readyId = '0;
    found   = 1'b0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        readyId = ID_W'(i);
        found   = 1'b1;
      end
    end
    readyValid = found && ifaceOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      activeQ <= '0;
      pendQ   <= '0;
      prevQ   <= '0;
    end else begin
      prevQ <= privIrq;
      if (strb.setEn) enableQ[cmdIdx] <= 1'b1;
      if (strb.clrEn) enableQ[cmdIdx] <= 1'b0;
      if (strb.eoi)   activeQ[cmdIdx] <= 1'b0;
      if (strb.ack) begin
        activeQ[readyId] <= 1'b1;
        pendQ[readyId]   <= 1'b0;
      end
      pendQ <= (strb.ack ? (pendQ & ~(NUM_IDS'(1) << readyId)) : pendQ)
               | edgeHit | ipiHit;
    end
  end

  // R4: the acknowledged ID is active in the following cycle
  a_r4_ack_sets_active: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |=> activeQ[$past(readyId)]);

  // R5: completion clears the active flag
  a_r5_eoi_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !strb.ack) |=> !activeQ[$past(cmdIdx)]);

  // R3: a disable write leaves the ID disabled
  a_r3_disable: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEn |=> !enableQ[$past(cmdIdx)]);

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_pkg::*;
#(
  parameter int NUM_SHARED = 32,
  parameter int NUM_CPUS   = 4,
  parameter int CPU_ID     = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [11:0]           busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  input  logic [31:0]           privIrq,
  input  logic [NUM_SHARED-1:0] sharedIrq,
  input  logic                  ipiRecvValid,
  input  logic [3:0]            ipiRecvId,
  input  logic [NUM_CPUS-1:0]   ipiRecvMask,
  output logic                  ipiSendValid,
  output logic [3:0]            ipiSendId,
  output logic [NUM_CPUS-1:0]   ipiSendMask,
  output logic                  irq
);

  localparam int NUM_IDS = PRIV_IDS + NUM_SHARED;
  localparam int ID_W    = $clog2(NUM_IDS);

  ctl_strb_t       strb;
  logic            ifaceOn;
  logic [63:0]     senseCfg;
  logic            readyValid;
  logic [ID_W-1:0] readyId;

  cpu_irq_ctrl #(
    .NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS), .ID_W(ID_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .readyValid(readyValid), .readyId(readyId),
    .ifaceOn(ifaceOn), .senseCfg(senseCfg), .strb(strb),
    .ipiSendValid(ipiSendValid), .ipiSendId(ipiSendId),
    .ipiSendMask(ipiSendMask)
  );

  cpu_irq_datapath #(
    .NUM_SHARED(NUM_SHARED), .NUM_CPUS(NUM_CPUS), .CPU_ID(CPU_ID),
    .NUM_IDS(NUM_IDS), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ifaceOn(ifaceOn),
    .senseCfg(senseCfg), .privIrq(privIrq), .sharedIrq(sharedIrq),
    .ipiRecvValid(ipiRecvValid), .ipiRecvId(ipiRecvId),
    .ipiRecvMask(ipiRecvMask),
    .readyValid(readyValid), .readyId(readyId)
  );

  assign irq = readyValid;

  // R2 / R9: no request to the core while the interface is off
  a_r2_irq_needs_on: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ifaceOn);

endmodule

// File: tb/cpu_irq_iface_tb.sv
module cpu_irq_iface_tb;

  localparam int NSH = 32;
  localparam int NCPU = 4;
  localparam logic [31:0] IDLE = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] privIrq = '0;
  logic [NSH-1:0] sharedIrq = '0;
  logic ipiSendValid;
  logic [3:0] ipiSendId;
  logic [NCPU-1:0] ipiSendMask;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cpu_irq_iface #(.NUM_SHARED(NSH), .NUM_CPUS(NCPU), .CPU_ID(0)) u_dut (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .privIrq(privIrq), .sharedIrq(sharedIrq),
    .ipiRecvValid(ipiSendValid), .ipiRecvId(ipiSendId),
    .ipiRecvMask(ipiSendMask),
    .ipiSendValid(ipiSendValid), .ipiSendId(ipiSendId),
    .ipiSendMask(ipiSendMask), .irq(irq)
  );

  // {shared line pattern, expected ready value}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0000, IDLE},
    {32'h0000_0001, 32'd32},
    {32'h8000_0000, 32'd63},
    {32'h0000_0110, 32'd36},
    {32'hF000_0000, 32'd60},
    {32'h0001_0000, 32'd48}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", 32'(irq), 32'd0);
    busRead(12'h000, rd); check("R1 ctrl", rd, 32'd0);
    busRead(12'h06C, rd); check("R1 ready idle", rd, IDLE);

    // R2: interface on, reads back
    busWrite(12'h000, 32'd1);
    busRead(12'h000, rd); check("R2 ctrl readback", rd, 32'd1);

    // R3: nothing enabled, shared line high gives no irq
    sharedIrq = 32'h1;
    @(negedge clk);
    check("R3 disabled no irq", 32'(irq), 32'd0);
    busWrite(12'h0A0, 32'd64);  // out of range, ignored
    busRead(12'h06C, rd); check("R3 out of range ignored", rd, IDLE);
    sharedIrq = '0;
    for (int i = 32; i < 64; i++) busWrite(12'h0A0, 32'(i));

    // R4 / R9: vector table walk over shared line patterns
    for (int v = 0; v < 6; v++) begin
      sharedIrq = VEC[v][63:32];
      @(negedge clk);
      check("R9 irq level", 32'(irq), 32'(VEC[v][63:32] != 0));
      busRead(12'h06C, rd); check("R4 lowest ready", rd, VEC[v][31:0]);
      if (rd != IDLE) busWrite(12'h0B4, rd);
    end
    sharedIrq = '0;

    // R4 / R5: active IDs are not re-presented; completion re-presents a held level
    sharedIrq = 32'h3;
    busRead(12'h06C, rd); check("R4 first", rd, 32'd32);
    busRead(12'h06C, rd); check("R4 next skips active", rd, 32'd33);
    busRead(12'h06C, rd); check("R4 all active idle", rd, IDLE);
    busWrite(12'h0B4, 32'd32);
    busRead(12'h06C, rd); check("R5 re-presented", rd, 32'd32);
    busWrite(12'h0B4, 32'd32);
    busWrite(12'h0B4, 32'd33);
    sharedIrq = '0;

    // R3: disable by ID
    busWrite(12'h0A4, 32'd33);
    sharedIrq = 32'h2;
    @(negedge clk);
    check("R3 disabled irq", 32'(irq), 32'd0);
    busRead(12'h06C, rd); check("R3 disabled read", rd, IDLE);
    sharedIrq = '0;
    busWrite(12'h0A0, 32'd33);

    // R2: interface off blocks irq and acknowledge
    sharedIrq = 32'h1;
    busWrite(12'h000, 32'd0);
    check("R2 off irq", 32'(irq), 32'd0);
    busRead(12'h06C, rd); check("R2 off read idle", rd, IDLE);
    busWrite(12'h000, 32'd1);
    busRead(12'h06C, rd); check("R2 no state change", rd, 32'd32);
    busWrite(12'h0B4, 32'd32);
    sharedIrq = '0;

    // R6: rising edge on ID 5 (bits 11:10 of 0x014 = 2)
    busWrite(12'h014, 32'(2) << 10);
    busRead(12'h014, rd); check("R6 sense readback", rd, 32'h0000_0800);
    busWrite(12'h0A0, 32'd5);
    @(negedge clk); privIrq[5] = 1'b1;
    @(negedge clk); privIrq[5] = 1'b0;
    busRead(12'h06C, rd); check("R6 rising latched", rd, 32'd5);
    busRead(12'h06C, rd); check("R6 edge consumed", rd, IDLE);
    busWrite(12'h0B4, 32'd5);

    // R6: falling edge on ID 20 (bits 9:8 of 0x018 = 3)
    busWrite(12'h018, 32'(3) << 8);
    busWrite(12'h0A0, 32'd20);
    @(negedge clk); privIrq[20] = 1'b1;
    @(negedge clk);
    check("R6 no event on rise", 32'(irq), 32'd0);
    privIrq[20] = 1'b0;
    busRead(12'h06C, rd); check("R6 falling latched", rd, 32'd20);
    busWrite(12'h0B4, 32'd20);

    // R6 / R7: level low on ID 7 (bits 15:14 of 0x014 = 1)
    busWrite(12'h014, (32'(2) << 10) | (32'(1) << 14));
    busWrite(12'h0A0, 32'd7);
    busRead(12'h06C, rd); check("R6 level low", rd, 32'd7);
    busWrite(12'h0B4, 32'd7);
    privIrq[7] = 1'b1;
    busRead(12'h06C, rd); check("R7 level removed", rd, IDLE);

    // R7: level high on ID 9 follows the line
    busWrite(12'h0A0, 32'd9);
    privIrq[9] = 1'b1;
    @(negedge clk);
    check("R7 level high irq", 32'(irq), 32'd1);
    privIrq[9] = 1'b0;
    @(negedge clk);
    check("R7 level drop irq", 32'(irq), 32'd0);
    busRead(12'h06C, rd); check("R7 withdrawn", rd, IDLE);

    // R8: inter-processor interrupt to self (mask bit 0), ID 15
    busWrite(12'h0A0, 32'd15);
    busWrite(12'h060, 32'h0000_010F);
    check("R8 send valid", 32'(ipiSendValid), 32'd1);
    check("R8 send id", 32'(ipiSendId), 32'd15);
    check("R8 send mask", 32'(ipiSendMask), 32'd1);
    busRead(12'h06C, rd); check("R8 self pending", rd, 32'd15);
    check("R8 pulse ended", 32'(ipiSendValid), 32'd0);
    busWrite(12'h0B4, 32'd15);
    // R8: mask selects only CPU 1, this CPU is untouched
    busWrite(12'h060, 32'h0000_020F);
    check("R8 other mask", 32'(ipiSendMask), 32'd2);
    busRead(12'h06C, rd); check("R8 not targeted", rd, IDLE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule